// File: doc/BRIEF.md
# Reset and Power-Down Mode Controller

This block turns three slow chip-level inputs into the enables that the rest of a line-interface front end follows. The inputs are an active-low reset, an active-high power-down request and a static role strap that tells the chip whether it sits at the exchange end (LT) or at the subscriber end (NT). From them the block drives seven outputs:

- a digital core enable;
- a word clock, with a nibble index that names the current slot of the word;
- a force-low request for the receive data pins;
- separate power-down lines for the analog receive and transmit paths;
- a master-clock source enable;
- a shutdown line for the external line driver.

The block is built around a three-state machine. `ST_RESET` is entered asynchronously whenever reset is low. `ST_RESET -> ST_ACTIVE` is taken once the synchronized reset releases and no power-down is requested. `ST_RESET -> ST_PWRDN` is taken once the synchronized reset releases and a power-down is requested. `ST_ACTIVE -> ST_PWRDN` is taken on a synchronized power-down request, and `ST_PWRDN -> ST_ACTIVE` is taken when that request is withdrawn.

Reset always wins over power-down. The power-down mapping depends on the role. At LT only the transmit path sleeps and the line driver is kept powered. At NT both analog paths sleep, the receive pins are forced low and the driver is shut down. A nibble timer produces the word clock and restarts at nibble 0 whenever the machine leaves reset.

Top module: `rpm_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs take their reset values without waiting for a clock edge. Those values are `core_en`=0, `word_clk`=1, `nib_idx`=0, `rx_force_low`=1, `arx_pd`=1, `atx_pd`=1 and `drv_shdn`=1.
- R2: A rising `rst_n` is passed through a two-flop synchronizer. The outputs still show reset values after the first and second rising clock edges, and leave reset on the third rising edge.
- R3: Reset dominates. With `rst_n` low, the R1 values hold whatever the level of `pd_req`.
- R4: A change of `pd_req` is passed through a two-flop synchronizer and takes effect on the third rising clock edge after it.
- R5: In ST_ACTIVE, for either role: `core_en`=1, `rx_force_low`=0, `arx_pd`=0, `atx_pd`=0, `mclk_en`=1 and `drv_shdn`=0.
- R6: In ST_PWRDN with `role_lt`=1: `core_en`=1, `rx_force_low`=0, `arx_pd`=0, `atx_pd`=1, `mclk_en`=1 and `drv_shdn`=0, so the driver is held powered.
- R7: In ST_PWRDN with `role_lt`=0: `core_en`=1, `rx_force_low`=1, `arx_pd`=1, `atx_pd`=1, `mclk_en`=1 and `drv_shdn`=1.
- R8: `mclk_en` is 0 in ST_RESET when `role_lt`=0, and is 1 in every state when `role_lt`=1.
- R9: While the word clock runs, which is in ST_ACTIVE and ST_PWRDN, `nib_idx` counts 0,1,...,NIBBLES-1 and wraps. `word_clk` is 1 for indices below NIBBLES/2 and 0 otherwise.
- R10: The first cycle after leaving ST_RESET shows `nib_idx`=0.
- R11: Moving between ST_ACTIVE and ST_PWRDN does not interrupt the nibble count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases through a synchronizer |
| pd_req | input | 1 | Active-high power-down request |
| role_lt | input | 1 | Static role strap: 1 = LT, 0 = NT |
| core_en | output | 1 | Digital core enable |
| word_clk | output | 1 | Word clock; held high when stopped |
| nib_idx | output | $clog2(NIBBLES) | Current nibble slot within the word |
| rx_force_low | output | 1 | Force the receive data pins low |
| arx_pd | output | 1 | Analog receive path power-down |
| atx_pd | output | 1 | Analog transmit path power-down |
| mclk_en | output | 1 | Master clock source (crystal driver) enable |
| drv_shdn | output | 1 | External line-driver shutdown |

## Verification
The bench builds the block with its default values, NIBBLES=4 and SYNC_STAGES=2. A three-edge latency and a four-cycle word therefore fit inside holds of a few cycles. As a result, every random power-down toggle and reset pulse is checked both at the exact edge where its effect lands and across word wraps while the inputs hold. The role strap is changed only during reset pulses, so both LT and NT mappings are covered for every state, including power-down requested during reset.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_PWRDN  = 2'd2
    } rpm_state_e;
endpackage

// File: rtl/rpm_sync.sv
module rpm_sync #(
    parameter int    STAGES  = 2,
    parameter logic  RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rpm_mode_fsm.sv
module rpm_mode_fsm
    import rpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_rel,
    input  logic       pd_s,
    input  logic       role_lt,
    output rpm_state_e state,
    output logic       core_en,
    output logic       wclk_run,
    output logic       rx_force_low,
    output logic       arx_pd,
    output logic       atx_pd,
    output logic       mclk_en,
    output logic       drv_shdn
);
    rpm_state_e state_q;
    rpm_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  if (rst_rel) state_d = pd_s ? ST_PWRDN : ST_ACTIVE;
            ST_ACTIVE: if (pd_s)    state_d = ST_PWRDN;
            ST_PWRDN:  if (!pd_s)   state_d = ST_ACTIVE;
            default:                state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        core_en      = 1'b1;
        wclk_run     = 1'b1;
        rx_force_low = 1'b0;
        arx_pd       = 1'b0;
        atx_pd       = 1'b0;
        mclk_en      = 1'b1;
        drv_shdn     = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                core_en      = 1'b0;
                wclk_run     = 1'b0;
                rx_force_low = 1'b1;
                arx_pd       = 1'b1;
                atx_pd       = 1'b1;
                mclk_en      = role_lt;
                drv_shdn     = 1'b1;
            end
            ST_ACTIVE: begin
            end
            ST_PWRDN: begin
                atx_pd       = 1'b1;
                rx_force_low = !role_lt;
                arx_pd       = !role_lt;
                drv_shdn     = !role_lt;
            end
            default: begin
                core_en  = 1'b0;
                wclk_run = 1'b0;
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/rpm_word_timer.sv
module rpm_word_timer #(
    parameter int NIBBLES = 4,
    localparam int NIB_W  = $clog2(NIBBLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [NIB_W-1:0] nib_idx,
    output logic             word_clk
);
    localparam logic [NIB_W-1:0] LAST_V = NIB_W'(NIBBLES - 1);
    localparam logic [NIB_W-1:0] HALF_V = NIB_W'(NIBBLES / 2);

    logic [NIB_W-1:0] nib_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nib_q <= '0;
        end else if (!run) begin
            nib_q <= '0;
        end else if (nib_q == LAST_V) begin
            nib_q <= '0;
        end else begin
            nib_q <= nib_q + 1'b1;
        end
    end

    assign nib_idx  = nib_q;
    assign word_clk = !run || (nib_q < HALF_V);
endmodule

// File: rtl/rpm_ctrl.sv
module rpm_ctrl
    import rpm_pkg::*;
#(
    parameter int NIBBLES     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int NIB_W      = $clog2(NIBBLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_req,
    input  logic             role_lt,
    output logic             core_en,
    output logic             word_clk,
    output logic [NIB_W-1:0] nib_idx,
    output logic             rx_force_low,
    output logic             arx_pd,
    output logic             atx_pd,
    output logic             mclk_en,
    output logic             drv_shdn
);
    logic       rst_rel;
    logic       pd_s;
    logic       wclk_run;
    rpm_state_e state;

    rpm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (1'b1),
        .q     (rst_rel)
    );

    rpm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pd_req),
        .q     (pd_s)
    );

    rpm_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_rel      (rst_rel),
        .pd_s         (pd_s),
        .role_lt      (role_lt),
        .state        (state),
        .core_en      (core_en),
        .wclk_run     (wclk_run),
        .rx_force_low (rx_force_low),
        .arx_pd       (arx_pd),
        .atx_pd       (atx_pd),
        .mclk_en      (mclk_en),
        .drv_shdn     (drv_shdn)
    );

    rpm_word_timer #(.NIBBLES(NIBBLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (wclk_run),
        .nib_idx  (nib_idx),
        .word_clk (word_clk)
    );

    logic unused_state;
    assign unused_state = ^state;
endmodule

// File: rtl/rpm_ctrl_chk.sv
module rpm_ctrl_chk #(
    parameter int NIBBLES = 4,
    localparam int NIB_W  = $clog2(NIBBLES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             role_lt,
    input logic             core_en,
    input logic             word_clk,
    input logic [NIB_W-1:0] nib_idx,
    input logic             rx_force_low,
    input logic             arx_pd,
    input logic             atx_pd,
    input logic             mclk_en,
    input logic             drv_shdn
);
    localparam logic [NIB_W-1:0] LAST_V = NIB_W'(NIBBLES - 1);

    // R1 R3
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_values_chk: assert (!core_en && word_clk && arx_pd && atx_pd && drv_shdn && rx_force_low);
        end
    end

    // R9
    stopped_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |-> word_clk && nib_idx == '0);

    // R9 R11
    nibble_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_en && $past(core_en) |->
            nib_idx == (($past(nib_idx) == LAST_V) ? '0 : $past(nib_idx) + 1'b1));

    // R10
    first_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |-> nib_idx == '0);

    // R6
    lt_driver_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        role_lt && core_en && atx_pd |-> !drv_shdn && !arx_pd && !rx_force_low);

    // R7
    nt_rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !role_lt && core_en && atx_pd |-> rx_force_low && arx_pd && drv_shdn);

    // R8
    lt_mclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        role_lt |-> mclk_en);
endmodule

bind rpm_ctrl rpm_ctrl_chk #(.NIBBLES(NIBBLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .role_lt      (role_lt),
    .core_en      (core_en),
    .word_clk     (word_clk),
    .nib_idx      (nib_idx),
    .rx_force_low (rx_force_low),
    .arx_pd       (arx_pd),
    .atx_pd       (atx_pd),
    .mclk_en      (mclk_en),
    .drv_shdn     (drv_shdn)
);

// File: tb/rpm_ctrl_bench.sv
module rpm_ctrl_bench;
    localparam int NIB = 4;
    localparam int M_RST = 0;
    localparam int M_ACT = 1;
    localparam int M_PD  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_req = 1'b0;
    logic       role_lt = 1'b1;
    logic       core_en, word_clk, rx_force_low, arx_pd, atx_pd, mclk_en, drv_shdn;
    logic [1:0] nib_idx;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int exp_nib = 0;

    always #2 clk = ~clk;

    rpm_ctrl #(.NIBBLES(NIB), .SYNC_STAGES(2)) u_rpm_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .role_lt(role_lt),
        .core_en(core_en), .word_clk(word_clk), .nib_idx(nib_idx),
        .rx_force_low(rx_force_low), .arx_pd(arx_pd), .atx_pd(atx_pd),
        .mclk_en(mclk_en), .drv_shdn(drv_shdn)
    );

    // {core_en, rx_force_low, arx_pd, atx_pd, mclk_en, drv_shdn}
    function automatic logic [5:0] exp_vec(int mode, logic lt);
        case (mode)
            M_RST:   return {1'b0, 1'b1, 1'b1, 1'b1, lt, 1'b1};
            M_ACT:   return 6'b100010;
            default: return lt ? 6'b100110 : 6'b111111;
        endcase
    endfunction

    task automatic check_mode(string tag, int mode);
        logic [5:0] act;
        logic [5:0] exp;
        act = {core_en, rx_force_low, arx_pd, atx_pd, mclk_en, drv_shdn};
        exp = exp_vec(mode, role_lt);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_word(string tag);
        logic [1:0] en;
        logic       ew;
        en = 2'(exp_nib);
        ew = (exp_nib < NIB / 2);
        checks++;
        if (nib_idx !== en || word_clk !== ew) begin
            errors++;
            $display("FAIL %s: nib/wclk actual=%0d/%b expected=%0d/%b", tag, nib_idx, word_clk, en, ew);
        end
    endtask

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            exp_nib = (exp_nib + 1) % NIB;
            check_word("R9 R11 word clock while running");
        end
    endtask

    int mode;

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check_mode("R1 reset values LT", M_RST);
        exp_nib = 0;
        check_word("R1 stopped word clock");

        // R2: release latency
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_mode("R2 still in reset after two edges", M_RST);
        @(negedge clk);
        check_mode("R2 R5 active after third edge", M_ACT);
        exp_nib = 0;
        check_word("R10 first nibble after reset");
        run_cycles(6);
        mode = M_ACT;

        for (int it = 0; it < 40; it++) begin
            if ($urandom_range(0, 3) != 0) begin
                // R4: power-down toggle
                pd_req = ~pd_req;
                @(negedge clk); exp_nib = (exp_nib + 1) % NIB;
                @(negedge clk); exp_nib = (exp_nib + 1) % NIB;
                check_mode("R4 pd not yet effective", mode);
                @(negedge clk); exp_nib = (exp_nib + 1) % NIB;
                mode = pd_req ? M_PD : M_ACT;
                check_mode(pd_req ? (role_lt ? "R6 LT power-down" : "R7 NT power-down") : "R5 active", mode);
                check_word("R11 count continues across pd");
            end else begin
                // R1 R3: async reset, optionally with pd held
                #1 rst_n = 1'b0;
                if ($urandom_range(0, 1) != 0) pd_req = 1'b1;
                #0.5;
                check_mode(pd_req ? "R3 reset dominates pd" : "R1 async reset", M_RST);
                @(negedge clk);
                role_lt = 1'($urandom_range(0, 1));
                @(negedge clk);
                check_mode("R8 reset mclk by role", M_RST);
                exp_nib = 0;
                check_word("R9 word clock held high in reset");
                rst_n = 1'b1;
                @(negedge clk);
                @(negedge clk);
                check_mode("R2 reset release latency", M_RST);
                @(negedge clk);
                mode = pd_req ? M_PD : M_ACT;
                check_mode("R2 R5 R6 R7 mode after release", mode);
                exp_nib = 0;
                check_word("R10 nibble zero after reset");
            end
            run_cycles($urandom_range(1, 5));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule